// File: doc/BRIEF.md
# SD Host Transfer Interrupt Status

This block keeps three interrupt status flags for the data side of an SD card host controller. The flags are transfer complete, block gap event and DMA boundary. They are set from falling edges of the data path's activity levels. Which level is watched depends on the transfer direction.

Software reads the flags from `status` and clears them by writing ones to them. A per-flag signal enable selects which flags drive the single interrupt line `irq`.

A DMA boundary pulse raises the DMA flag only while the current transfer has not yet completed. A transfer-start strobe re-arms it for the next transfer.

Top module: `sd_xfer_irq_status`

## Requirements
- R1: `status` bit 0 is transfer complete, bit 1 is block gap event and bit 2 is DMA boundary. All three bits read 0 after reset.
- R2: When `wr_en` is 1, each `wr_data` bit at 1 clears the matching status bit at the next clock edge. A `wr_data` bit at 0 leaves its status bit unchanged.
- R3: If a set condition and a clearing write hit the same bit in the same cycle, the bit ends up at 1.
- R4: A falling edge on an activity input means the input was sampled 1 at one clock edge and 0 at the next. The flag reads 1 from that second edge. The previous sample is taken as 0 right after reset.
- R5: With `dir_read`=1, a falling edge of `rd_active` sets bit 0.
- R6: With `dir_read`=0, a falling edge of `dat_busy` sets bit 0.
- R7: With `stop_gap_req`=1, bit 1 is set by a falling edge of `dat_busy` in a read (`dir_read`=1) and by a falling edge of `wr_active` in a write (`dir_read`=0).
- R8: With `stop_gap_req`=0, bit 1 is never set.
- R9: A `dma_boundary` pulse sets bit 2 while the transfer is armed. Reset and `xfer_start` arm the transfer.
- R10: Once bit 0 has been set, bit 2 is not set until the next `xfer_start`. This also holds for a pulse that comes in the same cycle as the completion. A pulse that comes in the same cycle as `xfer_start` is accepted.
- R11: `irq` is 1 exactly when some status bit and its `sig_en` bit are both 1. Status bits are recorded whatever `sig_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_read | input | 1 | Transfer direction, 1 = read |
| stop_gap_req | input | 1 | Stop-at-block-gap request |
| dat_busy | input | 1 | DAT line active level |
| rd_active | input | 1 | Read transfer active level |
| wr_active | input | 1 | Write transfer active level |
| dma_boundary | input | 1 | DMA buffer boundary reached pulse |
| xfer_start | input | 1 | New transfer start strobe |
| wr_en | input | 1 | Status clear write strobe |
| wr_data | input | 3 | Write-one-to-clear mask |
| sig_en | input | 3 | Per-flag interrupt signal enable |
| status | output | 3 | Status flags |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives the direction swap, so that a design which watches the wrong activity level for a flag shows up when the other level falls. It also targets three cases:

- A clearing write in the same cycle as a set. A design that lets the clear win loses the event.
- A DMA pulse in the same cycle as a completion, and a DMA pulse in the same cycle as a start strobe. A design with the wrong suppression window either raises a stale DMA flag or drops a valid one.
- Activity levels that are high during reset. A design that does not clear its edge history reports a false edge after reset.

// File: rtl/sd_xfer_irq_status.sv
module sd_xfer_irq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_read,
  input  logic       stop_gap_req,
  input  logic       dat_busy,
  input  logic       rd_active,
  input  logic       wr_active,
  input  logic       dma_boundary,
  input  logic       xfer_start,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  input  logic [2:0] sig_en,
  output logic [2:0] status,
  output logic       irq
);
  localparam int BIT_DONE = 0;
  localparam int BIT_GAP  = 1;
  localparam int BIT_DMA  = 2;

  logic dat_q, rd_q, wr_q, done_q;
  logic dat_fall, rd_fall, wr_fall;
  logic done_set, gap_set, dma_set;
  logic [2:0] clr_mask, set_mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {dat_q, rd_q, wr_q} <= '0;
    else        {dat_q, rd_q, wr_q} <= {dat_busy, rd_active, wr_active};

  assign dat_fall = dat_q & ~dat_busy;
  assign rd_fall  = rd_q  & ~rd_active;
  assign wr_fall  = wr_q  & ~wr_active;

  assign done_set = dir_read ? rd_fall : dat_fall;
  assign gap_set  = stop_gap_req & (dir_read ? dat_fall : wr_fall);
  assign dma_set  = dma_boundary & (xfer_start | ~done_q) & ~done_set;

  assign set_mask = {dma_set, gap_set, done_set};
  assign clr_mask = wr_en ? wr_data : 3'b000;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        done_q <= 1'b0;
    else if (done_set) done_q <= 1'b1;
    else if (xfer_start) done_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) status <= '0;
    else        status <= set_mask | (status & ~clr_mask);

  assign irq = |(status & sig_en);

  a_r2_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    (status[BIT_DONE] && wr_en && wr_data[BIT_DONE] && !done_set) |=> !status[BIT_DONE]);

  a_r2_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (status[BIT_GAP] && !(wr_en && wr_data[BIT_GAP])) |=> status[BIT_GAP]);

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_set && wr_en && wr_data[BIT_GAP]) |=> status[BIT_GAP]);

  a_r8_gap_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_gap_req |=> !$rose(status[BIT_GAP]));

  a_r10_dma_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !xfer_start) |=> !$rose(status[BIT_DMA]));

  a_r11_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_en == 3'b000) |-> !irq);
endmodule

// File: tb/tb_sd_xfer_irq_status.sv
module tb_sd_xfer_irq_status;
  logic clk = 0, rst_n = 0;
  logic dir_read = 0, stop_gap_req = 0, dat_busy = 0, rd_active = 0, wr_active = 0;
  logic dma_boundary = 0, xfer_start = 0, wr_en = 0;
  logic [2:0] wr_data = 0, sig_en = 0, status;
  logic irq;

  int checks = 0, failures = 0;
  bit finished = 0;
  string phase = "R1";

  // reference model state
  int m_st[3];
  bit p_dat, p_rd, p_wr, m_done;

  sd_xfer_irq_status dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_st[i]) m_st[i] = 0;
      p_dat = 0; p_rd = 0; p_wr = 0; m_done = 0;
    end else begin
      bit fd, fr, fw, tc, gp, dm;
      fd = p_dat && !dat_busy;
      fr = p_rd && !rd_active;
      fw = p_wr && !wr_active;
      if (dir_read) begin tc = fr; gp = stop_gap_req && fd; end
      else begin tc = fd; gp = stop_gap_req && fw; end
      dm = dma_boundary && !tc && (xfer_start || !m_done);
      for (int i = 0; i < 3; i++)
        if (wr_en && wr_data[i]) m_st[i] = 0;
      if (tc) m_st[0] = 1;
      if (gp) m_st[1] = 1;
      if (dm) m_st[2] = 1;
      if (tc) m_done = 1; else if (xfer_start) m_done = 0;
      p_dat = dat_busy; p_rd = rd_active; p_wr = wr_active;
    end
  end

  task automatic check_model();
    logic [2:0] exp_st;
    logic exp_irq;
    exp_st = {m_st[2][0], m_st[1][0], m_st[0][0]};
    exp_irq = |(exp_st & sig_en);
    checks++;
    if (status !== exp_st || irq !== exp_irq) begin
      failures++;
      $display("FAIL %s status=%b irq=%b expected status=%b irq=%b",
               phase, status, irq, exp_st, exp_irq);
    end
  endtask

  task automatic check_val(string tag, logic [2:0] exp_st);
    checks++;
    if (status !== exp_st) begin
      failures++;
      $display("FAIL %s status=%b expected %b", tag, status, exp_st);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_model();
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = 3'b111; step(); wr_en = 0; wr_data = 0;
  endtask

  initial begin
    // R4: levels high during reset must not produce a false edge afterwards
    dat_busy = 1; rd_active = 1; wr_active = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1 reset";
    check_val("R1", 3'b000);
    dat_busy = 0; rd_active = 0; wr_active = 0;
    step(); check_val("R4", 3'b000);

    phase = "R5 read complete";
    dir_read = 1; rd_active = 1; step(); rd_active = 0; step();
    check_val("R5", 3'b001);

    phase = "R2 w1c";
    wr_en = 1; wr_data = 3'b010; step(); wr_en = 0;
    check_val("R2", 3'b001);
    wr_en = 1; wr_data = 3'b001; step(); wr_en = 0;
    check_val("R2", 3'b000);

    phase = "R6 write complete";
    xfer_start = 1; step(); xfer_start = 0;
    dir_read = 0; dat_busy = 1; step(); dat_busy = 0; step();
    check_val("R6", 3'b001);
    clear_all();

    phase = "R7 gap";
    stop_gap_req = 1; wr_active = 1; step(); wr_active = 0; step();
    check_val("R7", 3'b010);
    clear_all();
    dir_read = 1; dat_busy = 1; step(); dat_busy = 0; step();
    check_val("R7", 3'b010);
    clear_all();

    phase = "R8 gap without request";
    stop_gap_req = 0; dat_busy = 1; step(); dat_busy = 0; step();
    check_val("R8", 3'b000);

    phase = "R3 set beats clear";
    stop_gap_req = 1; dat_busy = 1; step();
    dat_busy = 0; wr_en = 1; wr_data = 3'b010; step(); wr_en = 0;
    check_val("R3", 3'b010);
    clear_all();

    phase = "R9 R10 dma";
    xfer_start = 1; step(); xfer_start = 0;
    dma_boundary = 1; step(); dma_boundary = 0;
    check_val("R9", 3'b100);
    clear_all();
    rd_active = 1; step(); rd_active = 0; dma_boundary = 1; step(); dma_boundary = 0;
    check_val("R10", 3'b001);
    dma_boundary = 1; step(); dma_boundary = 0;
    check_val("R10", 3'b001);
    xfer_start = 1; dma_boundary = 1; step(); xfer_start = 0; dma_boundary = 0;
    check_val("R10", 3'b101);

    phase = "R11 irq";
    sig_en = 3'b010; step();
    checks++;
    if (irq !== 1'b0) begin failures++; $display("FAIL R11 irq=%b expected 0", irq); end
    sig_en = 3'b100; step();
    checks++;
    if (irq !== 1'b1) begin failures++; $display("FAIL R11 irq=%b expected 1", irq); end
    clear_all();

    phase = "random R2 R3 R4 R5 R6 R7 R8 R9 R10 R11";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) dat_busy = ~dat_busy;
      if ($urandom_range(0, 3) == 0) rd_active = ~rd_active;
      if ($urandom_range(0, 3) == 0) wr_active = ~wr_active;
      if ($urandom_range(0, 31) == 0) dir_read = ~dir_read;
      if ($urandom_range(0, 15) == 0) stop_gap_req = ~stop_gap_req;
      if ($urandom_range(0, 15) == 0) sig_en = 3'($urandom);
      dma_boundary = ($urandom_range(0, 5) == 0);
      xfer_start = ($urandom_range(0, 11) == 0);
      wr_en = ($urandom_range(0, 4) == 0);
      wr_data = 3'($urandom);
      step();
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule